// File: doc/BRIEF.md
# Vector Immediate Right-Shift Unit

This unit shifts every lane of a packed vector right by an amount fixed in the instruction. One 6-bit immediate, read together with a long-lane flag, sets both the lane width (8, 16, 32 or 64 bits) and the shift count. A signedness flag chooses a zero fill or a sign fill. Two optional per-lane stages can follow the shift: a rounding stage that adds back the last bit shifted out, and an accumulate stage that adds the matching destination lane.

The vector is 128 bits wide when the quad flag is set and 64 bits wide otherwise. Operands are taken in on a valid strobe. The result, an undefined-encoding flag and an output valid appear one clock later. Encodings that are not shifts, and quad operations whose register indices are odd, raise the undefined flag and give an all-zero result.

Top module: `simd_rshift_unit`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `in_valid` high and is low otherwise. After reset `out_valid`, `result` and `undef_enc` are zero.
- R2: With `long_lane` = 1 the lanes are 64 bits wide and the shift count is 64 − `imm6`, so `imm6` = 0 gives a count of 64.
- R3: With `long_lane` = 0 the lane width comes from the highest set bit of `imm6[5:3]`. Bit 5 gives 32-bit lanes and a count of 64 − `imm6`. Bit 4 gives 16-bit lanes and a count of 32 − `imm6`. Bit 3 gives 8-bit lanes and a count of 16 − `imm6`.
- R4: With `long_lane` = 0 and `imm6[5:3]` = 0, `undef_enc` is 1 and `result` is all zero.
- R5: With `quad` = 1 and either `src_idx_lsb` or `dst_idx_lsb` equal to 1, `undef_enc` is 1 and `result` is all zero.
- R6: With `is_unsigned` = 1 each lane is shifted with zero fill. With `is_unsigned` = 0 each lane is shifted with copies of its top bit.
- R7: A shift count equal to the lane width is legal. It gives zero for a zero-fill shift and all copies of the top bit for a sign-fill shift, and in that case the rounding bit is the lane's top bit.
- R8: With `round_en` = 1, one is added to a shifted lane whenever bit (count − 1) of the original lane is set.
- R9: With `accum_en` = 1 the destination lane is added to the shifted and possibly rounded lane, modulo 2^lane width. No carry passes into a neighbouring lane.
- R10: With `quad` = 0 only bits [63:0] of the operands are used and `result[127:64]` is zero. With `quad` = 1 all 128 bits are processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_vec | input | 128 | Vector to shift |
| dst_vec | input | 128 | Accumulate addend vector |
| imm6 | input | 6 | Encoded lane width and shift count |
| long_lane | input | 1 | Selects 64-bit lanes |
| is_unsigned | input | 1 | 1: zero fill, 0: sign fill |
| quad | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| src_idx_lsb | input | 1 | Low bit of the source register index |
| dst_idx_lsb | input | 1 | Low bit of the destination register index |
| round_en | input | 1 | Enables the rounding correction |
| accum_en | input | 1 | Enables the destination add |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Shifted vector |
| undef_enc | output | 1 | Encoding is undefined |

## Verification
On every cycle the assertions check the one-cycle valid handshake, that both undefined conditions raise the flag, that a flagged result is zero, and that the upper half is zero for 64-bit operations. The lane arithmetic cannot be checked that way: fill choice, the rounding bit at the count boundary, the accumulate wrap without carry between lanes, and the mapping of each immediate to a lane width and count. Those are shown only by the bench, which compares results against its own lane-by-lane model and against values worked out by hand.

// File: rtl/simd_rshift_pkg.sv
package simd_rshift_pkg;

    localparam int VEC_W   = 128;
    localparam int IMM_W   = 6;
    localparam int SHAMT_W = 7;
    localparam int N_SIZES = 4;

    typedef enum logic [1:0] {
        LANE8  = 2'd0,
        LANE16 = 2'd1,
        LANE32 = 2'd2,
        LANE64 = 2'd3
    } lane_sz_e;

    typedef struct packed {
        logic is_unsigned;
        logic round_en;
        logic accum_en;
    } lane_ctl_t;

    typedef struct packed {
        lane_sz_e               lsz;
        logic [SHAMT_W-1:0]     shamt;
        logic                   undef;
    } shift_dec_t;

    function automatic logic [SHAMT_W-1:0] count_from(input logic [SHAMT_W-1:0] base,
                                                      input logic [IMM_W-1:0] imm);
        return base - {1'b0, imm};
    endfunction

endpackage

// File: rtl/rshift_decode.sv
module rshift_decode
    import simd_rshift_pkg::*;
(
    input  logic [IMM_W-1:0] imm_i,
    input  logic             long_i,
    input  logic             quad_i,
    input  logic             src_lsb_i,
    input  logic             dst_lsb_i,
    output shift_dec_t       dec_o
);
    logic not_shift;
    logic bad_regs;

    always_comb begin
        dec_o.lsz   = LANE8;
        dec_o.shamt = '0;
        not_shift   = 1'b0;
        if (long_i) begin
            dec_o.lsz   = LANE64;
            dec_o.shamt = count_from(7'd64, imm_i);
        end else begin
            casez (imm_i[5:3])
                3'b1??: begin
                    dec_o.lsz   = LANE32;
                    dec_o.shamt = count_from(7'd64, imm_i);
                end
                3'b01?: begin
                    dec_o.lsz   = LANE16;
                    dec_o.shamt = count_from(7'd32, imm_i);
                end
                3'b001: begin
                    dec_o.lsz   = LANE8;
                    dec_o.shamt = count_from(7'd16, imm_i);
                end
                default: not_shift = 1'b1;
            endcase
        end
        bad_regs    = quad_i & (src_lsb_i | dst_lsb_i);
        dec_o.undef = not_shift | bad_regs;
    end
endmodule

// File: rtl/rshift_lane.sv
module rshift_lane
    import simd_rshift_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic [EW-1:0]      src_i,
    input  logic [EW-1:0]      dst_i,
    input  logic [SHAMT_W-1:0] sh_i,
    input  lane_ctl_t          ctl_i,
    output logic [EW-1:0]      res_o
);
    localparam int XW = EW + 1;

    logic signed [XW-1:0] ext;
    logic signed [XW-1:0] ext_sh;
    logic [EW-1:0]        shifted;
    logic [EW-1:0]        below;
    logic                 rbit;
    logic [EW-1:0]        rounded;

    always_comb begin
        ext     = $signed({(ctl_i.is_unsigned ? 1'b0 : src_i[EW-1]), src_i});
        ext_sh  = ext >>> sh_i;
        shifted = ext_sh[EW-1:0];
        below   = src_i >> (sh_i - 7'd1);
        rbit    = (sh_i != '0) & below[0];
        rounded = shifted + ((ctl_i.round_en & rbit) ? EW'(1) : EW'(0));
        res_o   = rounded + (ctl_i.accum_en ? dst_i : EW'(0));
    end
endmodule

// File: rtl/rshift_lane_array.sv
module rshift_lane_array
    import simd_rshift_pkg::*;
#(
    parameter int W = VEC_W
) (
    input  logic [W-1:0]       src_i,
    input  logic [W-1:0]       dst_i,
    input  lane_sz_e           lsz_i,
    input  logic [SHAMT_W-1:0] sh_i,
    input  lane_ctl_t          ctl_i,
    output logic [W-1:0]       res_o
);
    logic [W-1:0] by_size [N_SIZES];

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int EW = 8 << g;
        localparam int NL = W / EW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            rshift_lane #(.EW(EW)) lane_i (
                .src_i (src_i[l*EW +: EW]),
                .dst_i (dst_i[l*EW +: EW]),
                .sh_i  (sh_i),
                .ctl_i (ctl_i),
                .res_o (by_size[g][l*EW +: EW])
            );
        end
    end

    always_comb begin
        res_o = by_size[lsz_i];
    end
endmodule

// File: rtl/simd_rshift_unit.sv
module simd_rshift_unit
    import simd_rshift_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [127:0] src_vec,
    input  logic [127:0] dst_vec,
    input  logic [5:0]   imm6,
    input  logic         long_lane,
    input  logic         is_unsigned,
    input  logic         quad,
    input  logic         src_idx_lsb,
    input  logic         dst_idx_lsb,
    input  logic         round_en,
    input  logic         accum_en,
    output logic         out_valid,
    output logic [127:0] result,
    output logic         undef_enc
);
    localparam int HALF_W = VEC_W / 2;

    shift_dec_t       dec;
    lane_ctl_t        ctl;
    logic [VEC_W-1:0] src_sel;
    logic [VEC_W-1:0] dst_sel;
    logic [VEC_W-1:0] lanes_out;
    logic [VEC_W-1:0] res_d;

    rshift_decode dec_i (
        .imm_i     (imm6),
        .long_i    (long_lane),
        .quad_i    (quad),
        .src_lsb_i (src_idx_lsb),
        .dst_lsb_i (dst_idx_lsb),
        .dec_o     (dec)
    );

    always_comb begin
        ctl.is_unsigned = is_unsigned;
        ctl.round_en    = round_en;
        ctl.accum_en    = accum_en;
        src_sel = quad ? src_vec : {{HALF_W{1'b0}}, src_vec[HALF_W-1:0]};
        dst_sel = quad ? dst_vec : {{HALF_W{1'b0}}, dst_vec[HALF_W-1:0]};
    end

    rshift_lane_array #(.W(VEC_W)) arr_i (
        .src_i (src_sel),
        .dst_i (dst_sel),
        .lsz_i (dec.lsz),
        .sh_i  (dec.shamt),
        .ctl_i (ctl),
        .res_o (lanes_out)
    );

    always_comb begin
        if (dec.undef)
            res_d = '0;
        else if (quad)
            res_d = lanes_out;
        else
            res_d = {{HALF_W{1'b0}}, lanes_out[HALF_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            undef_enc <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= res_d;
                undef_enc <= dec.undef;
            end
        end
    end
endmodule

// File: rtl/simd_rshift_chk.sv
module simd_rshift_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [5:0]   imm6,
    input logic         long_lane,
    input logic         quad,
    input logic         src_idx_lsb,
    input logic         dst_idx_lsb,
    input logic         out_valid,
    input logic [127:0] result,
    input logic         undef_enc
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_not_shift_flagged_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !long_lane && imm6[5:3] == 3'b000) |=> undef_enc);

    assert_odd_index_flagged_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && quad && (src_idx_lsb || dst_idx_lsb)) |=> undef_enc);

    assert_undef_result_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && undef_enc) |-> (result == '0));

    assert_upper_half_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !quad) |=> (result[127:64] == '0));
endmodule

bind simd_rshift_unit simd_rshift_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .imm6        (imm6),
    .long_lane   (long_lane),
    .quad        (quad),
    .src_idx_lsb (src_idx_lsb),
    .dst_idx_lsb (dst_idx_lsb),
    .out_valid   (out_valid),
    .result      (result),
    .undef_enc   (undef_enc)
);

// File: tb/simd_rshift_unit_tb_top.sv
module simd_rshift_unit_tb_top;

    typedef struct packed {
        logic [127:0] src;
        logic [127:0] dst;
        logic [5:0]   imm;
        logic         lng;
        logic         uns;
        logic         qd;
        logic         sl;
        logic         dl;
        logic         rnd;
        logic         acc;
    } stim_t;

    localparam int NTBL = 10;
    localparam stim_t TBL [NTBL] = '{
        '{src:128'h8123_4567_89AB_CDEF_FEDC_BA98_7654_3210, dst:128'h0, imm:6'd8,  lng:1'b0, uns:1'b1, qd:1'b1, sl:1'b0, dl:1'b0, rnd:1'b0, acc:1'b0},
        '{src:128'h8123_4567_89AB_CDEF_FEDC_BA98_7654_3210, dst:128'h0, imm:6'd12, lng:1'b0, uns:1'b0, qd:1'b1, sl:1'b0, dl:1'b0, rnd:1'b1, acc:1'b0},
        '{src:128'hF0F0_1234_8000_7FFF_C3C3_0001_FFFF_8001, dst:128'h1111_2222_3333_4444_5555_6666_7777_8888, imm:6'd17, lng:1'b0, uns:1'b0, qd:1'b1, sl:1'b0, dl:1'b0, rnd:1'b1, acc:1'b1},
        '{src:128'hF0F0_1234_8000_7FFF_C3C3_0001_FFFF_8001, dst:128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, imm:6'd24, lng:1'b0, uns:1'b1, qd:1'b0, sl:1'b1, dl:1'b1, rnd:1'b0, acc:1'b1},
        '{src:128'h8000_0001_7FFF_FFFF_DEAD_BEEF_0000_0003, dst:128'h0123_4567_89AB_CDEF_0F0F_0F0F_F0F0_F0F0, imm:6'd33, lng:1'b0, uns:1'b0, qd:1'b1, sl:1'b0, dl:1'b0, rnd:1'b1, acc:1'b1},
        '{src:128'h8000_0001_7FFF_FFFF_DEAD_BEEF_0000_0003, dst:128'h0, imm:6'd50, lng:1'b0, uns:1'b1, qd:1'b1, sl:1'b0, dl:1'b0, rnd:1'b1, acc:1'b0},
        '{src:128'hC000_0000_0000_0001_8000_0000_0000_0000, dst:128'h5, imm:6'd0,  lng:1'b1, uns:1'b0, qd:1'b1, sl:1'b0, dl:1'b0, rnd:1'b1, acc:1'b0},
        '{src:128'hC000_0000_0000_0001_8765_4321_0FED_CBA9, dst:128'h1000_0000_0000_0000_0000_0000_0000_0001, imm:6'd40, lng:1'b1, uns:1'b0, qd:1'b1, sl:1'b0, dl:1'b0, rnd:1'b1, acc:1'b1},
        '{src:128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, dst:128'h0, imm:6'd63, lng:1'b0, uns:1'b0, qd:1'b0, sl:1'b0, dl:1'b0, rnd:1'b1, acc:1'b0},
        '{src:128'h1, dst:128'h0, imm:6'd7, lng:1'b0, uns:1'b1, qd:1'b0, sl:1'b0, dl:1'b0, rnd:1'b0, acc:1'b0}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] src_vec, dst_vec;
    logic [5:0]   imm6;
    logic         long_lane, is_unsigned, quad, src_idx_lsb, dst_idx_lsb, round_en, accum_en;
    logic         out_valid;
    logic [127:0] result;
    logic         undef_enc;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    simd_rshift_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec), .dst_vec(dst_vec),
        .imm6(imm6), .long_lane(long_lane), .is_unsigned(is_unsigned), .quad(quad),
        .src_idx_lsb(src_idx_lsb), .dst_idx_lsb(dst_idx_lsb), .round_en(round_en),
        .accum_en(accum_en), .out_valid(out_valid), .result(result), .undef_enc(undef_enc)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lane-by-lane reference built from R2..R10
    function automatic void model(input stim_t s, output logic [127:0] r, output logic u);
        int ew, sh, nl;
        logic [63:0]  m, x, d, y;
        logic [127:0] v;
        logic         bad;
        bad = 1'b0; ew = 8; sh = 0;
        if (s.lng)         begin ew = 64; sh = 64 - int'(s.imm); end
        else if (s.imm[5]) begin ew = 32; sh = 64 - int'(s.imm); end
        else if (s.imm[4]) begin ew = 16; sh = 32 - int'(s.imm); end
        else if (s.imm[3]) begin ew = 8;  sh = 16 - int'(s.imm); end
        else bad = 1'b1;
        u = bad || (s.qd && (s.sl || s.dl));
        r = '0;
        if (u) return;
        nl = (s.qd ? 128 : 64) / ew;
        m  = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
        for (int i = 0; i < nl; i++) begin
            x = 64'(s.src >> (i * ew)) & m;
            d = 64'(s.dst >> (i * ew)) & m;
            v = {64'h0, x};
            if (!s.uns && x[ew-1]) v = v | ~{64'h0, m};
            v = 128'($signed(v) >>> sh);
            y = v[63:0] & m;
            if (s.rnd && x[sh-1]) y = y + 64'd1;
            if (s.acc) y = y + d;
            y = y & m;
            r = r | (128'(y) << (i * ew));
        end
    endfunction

    task automatic issue(input stim_t s);
        @(negedge clk);
        src_vec = s.src; dst_vec = s.dst; imm6 = s.imm; long_lane = s.lng;
        is_unsigned = s.uns; quad = s.qd; src_idx_lsb = s.sl; dst_idx_lsb = s.dl;
        round_en = s.rnd; accum_en = s.acc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic stim_t mk(input logic [127:0] s, input logic [127:0] d, input logic [5:0] imm,
                                 input logic lng, input logic uns, input logic qd, input logic sl,
                                 input logic dl, input logic rnd, input logic acc);
        stim_t t;
        t.src = s; t.dst = d; t.imm = imm; t.lng = lng; t.uns = uns; t.qd = qd;
        t.sl = sl; t.dl = dl; t.rnd = rnd; t.acc = acc;
        return t;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] er;
        logic         eu;
        rst = 1'b1; in_valid = 1'b0; src_vec = '0; dst_vec = '0; imm6 = '0;
        long_lane = 1'b0; is_unsigned = 1'b0; quad = 1'b0; src_idx_lsb = 1'b0;
        dst_idx_lsb = 1'b0; round_en = 1'b0; accum_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", 128'(out_valid), 128'd0);
        chk("R1 reset result", result, 128'd0);
        chk("R1 reset undef", 128'(undef_enc), 128'd0);
        rst = 1'b0;

        // Table walk against the reference model (R2 R3 R6 R8 R9 R10)
        for (int k = 0; k < NTBL; k++) begin
            model(TBL[k], er, eu);
            issue(TBL[k]);
            chk("R1 out_valid after strobe", 128'(out_valid), 128'd1);
            chk("R2/R3/R6/R8/R9 table result", result, er);
            chk("R4/R5 table undef", 128'(undef_enc), 128'(eu));
        end
        @(negedge clk);
        chk("R1 out_valid drops", 128'(out_valid), 128'd0);

        // R7: count 8 on 8-bit lanes, zero fill, rounding bit is the top bit
        issue(mk(128'h80FF_7F01_8000_FF01, 128'h0, 6'd8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
        chk("R7 full-width logical with round", result, 128'h0101_0000_0100_0100);
        // R7: full-width sign fill
        issue(mk(128'h80FF_7F01_8000_FF01, 128'h0, 6'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        chk("R7 full-width arithmetic", result, 128'hFFFF_0000_FF00_FF00);
        // R4: non-shift encoding
        issue(mk(128'hFFFF, 128'h0, 6'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        chk("R4 undef flag", 128'(undef_enc), 128'd1);
        chk("R4 zero result", result, 128'd0);
        // R5: quad with odd destination index
        issue(mk(128'hFFFF, 128'h0, 6'd12, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
        chk("R5 undef flag", 128'(undef_enc), 128'd1);
        chk("R5 zero result", result, 128'd0);
        // R2 R9 R10: long lane count 4, accumulate wraps, upper half ignored
        issue(mk(128'hAAAA_0000_0000_0000_0000_0000_0000_00F0, 128'h5555_0000_0000_0000_FFFF_FFFF_FFFF_FFF2,
                 6'd60, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1));
        chk("R2/R9/R10 long accumulate wrap", result, 128'h1);
        chk("R10 non-quad defined", 128'(undef_enc), 128'd0);
        // R9: per-lane wrap without carry between lanes
        issue(mk({16{8'hFE}}, {16{8'h82}}, 6'd15, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
        chk("R9 lane isolation", result, {16{8'h01}});
        // R8 R6 R3: 16-bit arithmetic count 2 with rounding
        issue(mk({8{16'h8003}}, 128'h0, 6'd30, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
        chk("R8 arithmetic round 16-bit", result, 128'hE001_E001_E001_E001);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule